// File: doc/BRIEF.md
# Interrupt-Triggered Single-Unit Transfer Engine

This engine moves one data unit between two byte-addressed locations each time a start request is accepted. It reaches memory through a simple bus master port: a 24-bit address, a 16-bit data bus, a read strobe, and separate strobes for the low and the high byte of a write. One descriptor holds the source pointer, the destination pointer, the unit size, a step rule for each pointer and a transfer counter. The descriptor is written through a load port while the engine is idle, and the write arms the engine. Two configuration inputs say whether the source region and the destination region are 8 or 16 bits wide.

Twenty-five request lines can start a transfer: 24 interrupt lines and one software start. Requests are latched as they arrive, and the lowest-numbered pending request is served first. Each transfer runs a fixed sequence. Three fetch-slot states come first. Then come the read accesses, one dummy state and the write accesses. Each access takes two states, and an access becomes byte-wide when the region is narrow or the pointer is odd. After the last write state, both pointers step by the unit size and the counter decrements. When the counter reaches zero, the engine disarms and pulses a completion output that can feed the interrupt controller.

The reset input is asynchronous and active low. It is expected to be released synchronously by the surrounding reset logic.

Top module: `udma_engine`

## Requirements
- R1: The unit size is encoded as 0 = 1 byte, 1 = 2 bytes and 2 (or 3) = 4 bytes. A transfer copies the bytes at source pointer + i to destination pointer + i, for i from 0 up to the size minus 1.
- R2: After each transfer, each pointer follows its own step code: 0 = hold, 1 = add the unit size, 2 = subtract the unit size.
- R3: The counter decrements once per transfer, and a loaded value of 0 gives 2^CNT_W transfers (65536 at the default width). When the counter reaches zero, `done` is high for exactly one cycle, the first cycle with `busy` low. After that, no further request is served until the next load.
- R4: Request index i corresponds to `irq[i]` for i = 0..23, and the software start has index 24. `svc_id` shows the index being served and stays constant while `busy` is high.
- R5: Among the pending requests, the lowest index is served first. A request that arrives during a transfer stays pending until it is served.
- R6: A transfer takes 3 fetch states, then the read accesses, then 1 dummy state, then the write accesses. Every access lasts 2 states. In the dummy state the address holds its last read value and all strobes are low. A word unit between two even pointers in 16-bit regions takes 8 states in total.
- R7: A side uses word accesses (unit size / 2 of them) only when the unit is 2 or 4 bytes, its region is 16 bits wide and its pointer is even. Otherwise it uses one byte access per byte. `busy` therefore lasts 3 + 2·reads + 1 + 2·writes cycles.
- R8: On a 16-bit region, a byte at an even address uses data bits 7:0 and `bus_wr`, and a byte at an odd address uses bits 15:8 and `bus_hwr`. On an 8-bit region, every byte uses bits 7:0 and `bus_wr`. A word access uses both strobes.
- R9: `cfg_load` has no effect while `busy` is high. While the engine is idle, `cfg_load` loads the whole descriptor and arms the engine.
- R10: After reset the engine is idle and unarmed, with all strobes and `done` low. No request is served before the first load.
- R11: `bus_rd` never overlaps a write strobe, and no strobe is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 24 | Interrupt start requests, index 0..23 |
| soft_start | input | 1 | Software start request, index 24 |
| cfg_load | input | 1 | Load the descriptor and arm (honoured only when idle) |
| cfg_src | input | 24 | Source pointer |
| cfg_dst | input | 24 | Destination pointer |
| cfg_unit | input | 2 | Unit size code |
| cfg_src_step | input | 2 | Source step code |
| cfg_dst_step | input | 2 | Destination step code |
| cfg_count | input | 16 | Transfer counter (0 means 2^CNT_W) |
| src_wide | input | 1 | Source region is 16 bits wide |
| dst_wide | input | 1 | Destination region is 16 bits wide |
| bus_addr | output | 24 | Bus address |
| bus_rdata | input | 16 | Read data |
| bus_wdata | output | 16 | Write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Low-byte write strobe |
| bus_hwr | output | 1 | High-byte write strobe |
| busy | output | 1 | A transfer sequence is running |
| svc_id | output | 5 | Index of the request being served |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle the properties that hold at any instant. Reads and writes never overlap, and no strobe rises outside a transfer. The dummy state holds the address with the strobes low, and the fetch slot is three states long. `done` is a one-cycle pulse that only appears when the engine is disarmed. The served index never skips a lower pending request, and the descriptor is frozen during a transfer. Only the bench scenarios can show the data itself arriving on the right byte lanes, the pointer steps between transfers, the cycle counts of every access plan, the 2^CNT_W run for a zero count, and a load attempted mid-transfer leaving the next transfer unchanged.

// File: rtl/udma_pkg.sv
package udma_pkg;

  localparam int BUS_W = 16;
  localparam int BUF_W = 32;

  typedef enum logic [1:0] {UNIT_BYTE = 2'd0, UNIT_WORD = 2'd1, UNIT_LONG = 2'd2} unit_e;
  typedef enum logic [1:0] {STEP_HOLD = 2'd0, STEP_UP = 2'd1, STEP_DOWN = 2'd2} step_e;
  typedef enum logic [2:0] {PH_IDLE, PH_FETCH, PH_READ, PH_DUMMY, PH_WRITE} phase_e;

  // bytes in one unit; code 3 behaves as the 4-byte unit
  function automatic logic [2:0] unit_bytes(input logic [1:0] u);
    case (u)
      UNIT_BYTE: return 3'd1;
      UNIT_WORD: return 3'd2;
      default:   return 3'd4;
    endcase
  endfunction

  // a side moves whole words only on a 16-bit region from an even pointer
  function automatic logic word_path(input logic [1:0] u, input logic wide, input logic a0);
    return (u != UNIT_BYTE) && wide && !a0;
  endfunction

  function automatic logic [2:0] access_count(input logic [1:0] u, input logic wide, input logic a0);
    return word_path(u, wide, a0) ? (unit_bytes(u) >> 1) : unit_bytes(u);
  endfunction

endpackage

// File: rtl/udma_arb.sv
module udma_arb #(
  parameter int N   = 25,
  parameter int IDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic           take,
  output logic [N-1:0]   pend,
  output logic           any,
  output logic [IDW-1:0] pick
);

  logic [N-1:0] pend_q, pend_d, clr;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_q[i]) pick = IDW'(i);
    end
    any = |pend_q;
    clr = take ? (N'(1) << pick) : '0;
    pend_d = (pend_q & ~clr) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

endmodule

// File: rtl/udma_seq.sv
module udma_seq
  import udma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] n_rd,
  input  logic [2:0] n_wr,
  output phase_e     phase,
  output logic [1:0] idx,
  output logic       half,
  output logic       last
);

  phase_e     ph_q, ph_d;
  logic [1:0] idx_q, idx_d, rd_m1, wr_m1;
  logic       half_q, half_d;

  assign rd_m1 = 2'(n_rd - 3'd1);
  assign wr_m1 = 2'(n_wr - 3'd1);

  always_comb begin
    ph_d   = ph_q;
    idx_d  = idx_q;
    half_d = half_q;
    case (ph_q)
      PH_IDLE: if (start) begin
        ph_d = PH_FETCH; idx_d = '0; half_d = 1'b0;
      end
      PH_FETCH: if (idx_q == 2'd2) begin
        ph_d = PH_READ; idx_d = '0; half_d = 1'b0;
      end else begin
        idx_d = idx_q + 2'd1;
      end
      PH_READ: if (!half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        if (idx_q == rd_m1) ph_d = PH_DUMMY;   // index kept: dummy reuses last read address
        else                idx_d = idx_q + 2'd1;
      end
      PH_DUMMY: begin
        ph_d = PH_WRITE; idx_d = '0; half_d = 1'b0;
      end
      PH_WRITE: if (!half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        if (idx_q == wr_m1) ph_d = PH_IDLE;
        else                idx_d = idx_q + 2'd1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      half_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      half_q <= half_d;
    end
  end

  assign phase = ph_q;
  assign idx   = idx_q;
  assign half  = half_q;
  assign last  = (ph_q == PH_WRITE) && half_q && (idx_q == wr_m1);

endmodule

// File: rtl/udma_engine.sv
module udma_engine
  import udma_pkg::*;
#(
  parameter int AW    = 24,
  parameter int CNT_W = 16,
  parameter int N_IRQ = 24,
  localparam int NSRC = N_IRQ + 1,
  localparam int IDW  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq,
  input  logic              soft_start,
  input  logic              cfg_load,
  input  logic [AW-1:0]     cfg_src,
  input  logic [AW-1:0]     cfg_dst,
  input  logic [1:0]        cfg_unit,
  input  logic [1:0]        cfg_src_step,
  input  logic [1:0]        cfg_dst_step,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              src_wide,
  input  logic              dst_wide,
  output logic [AW-1:0]     bus_addr,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic [BUS_W-1:0]  bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              bus_hwr,
  output logic              busy,
  output logic [IDW-1:0]    svc_id,
  output logic              done
);

  function automatic logic [AW-1:0] stepped(input logic [AW-1:0] p, input logic [1:0] st,
                                            input logic [2:0] n);
    case (st)
      STEP_UP:   return p + AW'(n);
      STEP_DOWN: return p - AW'(n);
      default:   return p;
    endcase
  endfunction

  // descriptor and working state
  logic [AW-1:0]    src_q, src_d, dst_q, dst_d;
  logic [1:0]       unit_q, unit_d, sstep_q, sstep_d, dstep_q, dstep_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_nx;
  logic             active_q, active_d, done_q, done_d;
  logic [BUF_W-1:0] buf_q, buf_d;
  logic [IDW-1:0]   id_q, id_d;

  logic [NSRC-1:0]  pend;
  logic             any_pend, start, idle, load_ok, finish, half;
  logic [IDW-1:0]   pick;
  phase_e           phase;
  logic [1:0]       k;
  logic             s_word, d_word;
  logic [2:0]       n_rd, n_wr, nbytes, s_off, d_off;
  logic [AW-1:0]    src_a, dst_a;
  logic [7:0]       rbyte, wbyte;

  assign idle    = (phase == PH_IDLE);
  assign load_ok = cfg_load && idle;
  assign start   = idle && active_q && any_pend;

  udma_arb #(.N(NSRC), .IDW(IDW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req({soft_start, irq}), .take(start),
    .pend(pend), .any(any_pend), .pick(pick)
  );

  assign nbytes = unit_bytes(unit_q);
  assign s_word = word_path(unit_q, src_wide, src_q[0]);
  assign d_word = word_path(unit_q, dst_wide, dst_q[0]);
  assign n_rd   = access_count(unit_q, src_wide, src_q[0]);
  assign n_wr   = access_count(unit_q, dst_wide, dst_q[0]);

  udma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .n_rd(n_rd), .n_wr(n_wr),
    .phase(phase), .idx(k), .half(half), .last(finish)
  );

  // access address: byte offset k or word offset 2k from the pointer
  assign s_off = s_word ? {k, 1'b0} : {1'b0, k};
  assign d_off = d_word ? {k, 1'b0} : {1'b0, k};
  assign src_a = src_q + AW'(s_off);
  assign dst_a = dst_q + AW'(d_off);

  assign rbyte = (src_wide && src_a[0]) ? bus_rdata[15:8] : bus_rdata[7:0];
  assign wbyte = buf_q[{k, 3'b000} +: 8];

  assign bus_addr  = (phase == PH_WRITE) ? dst_a : src_a;
  assign bus_rd    = (phase == PH_READ);
  assign bus_wdata = d_word ? buf_q[{k[0], 4'b0000} +: 16] : {wbyte, wbyte};
  assign bus_wr    = (phase == PH_WRITE) && (d_word || !(dst_wide && dst_a[0]));
  assign bus_hwr   = (phase == PH_WRITE) && (d_word || (dst_wide && dst_a[0]));

  assign cnt_nx = cnt_q - CNT_W'(1);

  always_comb begin
    src_d    = src_q;
    dst_d    = dst_q;
    unit_d   = unit_q;
    sstep_d  = sstep_q;
    dstep_d  = dstep_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    buf_d    = buf_q;
    id_d     = id_q;
    done_d   = 1'b0;
    if (load_ok) begin
      src_d    = cfg_src;
      dst_d    = cfg_dst;
      unit_d   = cfg_unit;
      sstep_d  = cfg_src_step;
      dstep_d  = cfg_dst_step;
      cnt_d    = cfg_count;
      active_d = 1'b1;
    end
    if (start) id_d = pick;
    if (phase == PH_READ && half) begin
      if (s_word) buf_d[{k[0], 4'b0000} +: 16] = bus_rdata;
      else        buf_d[{k, 3'b000} +: 8]      = rbyte;
    end
    if (finish) begin
      src_d = stepped(src_q, sstep_q, nbytes);
      dst_d = stepped(dst_q, dstep_q, nbytes);
      cnt_d = cnt_nx;
      if (cnt_nx == '0) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      unit_q   <= '0;
      sstep_q  <= '0;
      dstep_q  <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      buf_q    <= '0;
      id_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      if (load_ok || finish) begin
        src_q   <= src_d;
        dst_q   <= dst_d;
        cnt_q   <= cnt_d;
      end
      if (load_ok) begin
        unit_q  <= unit_d;
        sstep_q <= sstep_d;
        dstep_q <= dstep_d;
      end
      if (phase == PH_READ) buf_q <= buf_d;
      if (start)            id_q  <= id_d;
      active_q <= active_d;
      done_q   <= done_d;
    end
  end

  assign busy   = !idle;
  assign svc_id = id_q;
  assign done   = done_q;

endmodule

// File: rtl/udma_engine_chk.sv
module udma_engine_chk
  import udma_pkg::*;
#(
  parameter int AW    = 24,
  parameter int CNT_W = 16,
  parameter int NSRC  = 25,
  parameter int IDW   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic             bus_hwr,
  input logic             busy,
  input logic             done,
  input logic [IDW-1:0]   svc_id,
  input phase_e           phase,
  input logic [NSRC-1:0]  pend,
  input logic             active_q,
  input logic [AW-1:0]    src_q,
  input logic [AW-1:0]    dst_q,
  input logic [CNT_W-1:0] cnt_q
);

  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && (bus_wr || bus_hwr)));

  assert_strobe_in_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr || bus_hwr) |-> busy);

  assert_dummy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY) |-> (bus_addr == $past(bus_addr)) && !bus_rd && !bus_wr && !bus_hwr);

  assert_fetch_three_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && $past(phase) == PH_FETCH) |-> ($past(phase, 3) == PH_FETCH));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_disarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !active_q);

  assert_lowest_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (($past(pend) & ((NSRC'(1) << svc_id) - NSRC'(1))) == '0));

  assert_id_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(svc_id));

  assert_desc_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));

endmodule

bind udma_engine udma_engine_chk #(.AW(AW), .CNT_W(CNT_W), .NSRC(NSRC), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_hwr(bus_hwr), .busy(busy), .done(done), .svc_id(svc_id), .phase(phase),
  .pend(pend), .active_q(active_q), .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q)
);

// File: tb/udma_engine_test.sv
`timescale 1ns/1ps
module udma_engine_test;

  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] irq;
  logic        soft_start, cfg_load, src_wide, dst_wide;
  logic [23:0] cfg_src, cfg_dst, bus_addr;
  logic [1:0]  cfg_unit, cfg_src_step, cfg_dst_step;
  logic [CW-1:0] cfg_count;
  logic [15:0] bus_rdata, bus_wdata;
  logic        bus_rd, bus_wr, bus_hwr, busy, done;
  logic [4:0]  svc_id;
  logic [7:0]  dmem [0:255];
  int          total = 0, fails = 0;

  always #2 clk = ~clk;

  udma_engine #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .soft_start(soft_start), .cfg_load(cfg_load),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_unit(cfg_unit), .cfg_src_step(cfg_src_step),
    .cfg_dst_step(cfg_dst_step), .cfg_count(cfg_count), .src_wide(src_wide), .dst_wide(dst_wide),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_hwr(bus_hwr), .busy(busy), .svc_id(svc_id), .done(done)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // source memory model, lanes per R8
  always_comb begin
    if (src_wide) bus_rdata = {pat({bus_addr[23:1], 1'b1}), pat({bus_addr[23:1], 1'b0})};
    else          bus_rdata = {8'h00, pat(bus_addr)};
  end

  // destination capture, lanes per R8
  always @(negedge clk) begin
    if (dst_wide) begin
      if (bus_wr)  dmem[{bus_addr[7:1], 1'b0}] <= bus_wdata[7:0];
      if (bus_hwr) dmem[{bus_addr[7:1], 1'b1}] <= bus_wdata[15:8];
    end else if (bus_wr) begin
      dmem[bus_addr[7:0]] <= bus_wdata[7:0];
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_dmem();
    for (int i = 0; i < 256; i++) dmem[i] = 8'hEE;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; soft_start = 1'b0; cfg_load = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input logic [23:0] s, input logic [23:0] d, input logic [1:0] u,
                      input logic [1:0] ss, input logic [1:0] ds, input logic [CW-1:0] c);
    cfg_src = s; cfg_dst = d; cfg_unit = u; cfg_src_step = ss; cfg_dst_step = ds;
    cfg_count = c; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic wait_busy();
    for (int g = 0; g < 100 && !busy; g++) @(negedge clk);
  endtask

  task automatic wait_idle(inout int len);
    for (int g = 0; g < 100 && busy; g++) begin
      @(negedge clk);
      if (busy) len++;
    end
  endtask

  // one soft-start transfer; len = busy cycles, dn = done on first idle cycle, dn2 = one later
  task automatic run(output int len, output bit dn, output bit dn2);
    soft_start = 1'b1;
    @(negedge clk);
    soft_start = 1'b0;
    wait_busy();
    len = busy ? 1 : 0;
    wait_idle(len);
    dn = done;
    @(negedge clk);
    dn2 = done;
  endtask

  function automatic int accesses(input int u, input bit wide, input bit a0);
    int sz = 1 << u;
    if (u == 0) return 1;
    return (wide && !a0) ? sz / 2 : sz;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int len, idx;
    bit dn, dn2, seen;
    logic [23:0] sp, dp;
    logic [31:0] act, exp;
    int ids [4];

    src_wide = 1'b1; dst_wide = 1'b1;
    cfg_src = '0; cfg_dst = '0; cfg_unit = '0; cfg_src_step = '0; cfg_dst_step = '0; cfg_count = '0;
    do_reset();

    // R10: reset state, and no service before a load
    chk("R10 busy", busy, 0);
    chk("R10 strobes", {bus_rd, bus_wr, bus_hwr}, 0);
    chk("R10 done", done, 0);
    soft_start = 1'b1; @(negedge clk); soft_start = 1'b0;
    seen = 0;
    repeat (30) begin @(negedge clk); if (busy) seen = 1; end
    chk("R10 unarmed no transfer", seen, 0);

    // sweep: unit x region widths x pointer parity, step codes rotate (R1 R2 R3 R6 R7 R8)
    idx = 0;
    for (int u = 0; u < 3; u++)
      for (int sw = 0; sw < 2; sw++)
        for (int dw = 0; dw < 2; dw++)
          for (int so = 0; so < 2; so++)
            for (int dof = 0; dof < 2; dof++) begin
              int sz = 1 << u;
              int ss = idx % 3;
              int ds = (idx / 3) % 3;
              idx++;
              do_reset();
              src_wide = sw[0]; dst_wide = dw[0];
              sp = 24'h001040 + 24'(so);
              dp = 24'h000080 + 24'(dof);
              load(sp, dp, 2'(u), 2'(ss), 2'(ds), CW'(2));
              for (int t = 0; t < 2; t++) begin
                clr_dmem();
                run(len, dn, dn2);
                chk("R7 cycle length", len,
                    3 + 2 * accesses(u, sw[0], sp[0]) + 1 + 2 * accesses(u, dw[0], dp[0]));
                if (u == 1 && sw == 1 && dw == 1 && so == 0 && dof == 0)
                  chk("R6 aligned word length", len, 8);
                act = '0; exp = '0;
                for (int b = 0; b < sz; b++) begin
                  act[8*b +: 8] = dmem[8'(dp[7:0] + 8'(b))];
                  exp[8*b +: 8] = pat(sp + 24'(b));
                end
                if (t == 0) chk("R1 R8 unit data", act, exp);
                else        chk("R2 stepped pointers data", act, exp);
                chk("R3 done at terminal count", dn, t == 1);
                chk("R3 done one cycle", dn2, 0);
                if (ss == 1) sp = sp + 24'(sz); else if (ss == 2) sp = sp - 24'(sz);
                if (ds == 1) dp = dp + 24'(sz); else if (ds == 2) dp = dp - 24'(sz);
              end
            end

    // R3: zero count gives 2^CW transfers, then disarmed
    do_reset();
    src_wide = 1'b1; dst_wide = 1'b1;
    load(24'h001040, 24'h000080, 2'd0, 2'd1, 2'd1, '0);
    for (int i = 1; i <= 16; i++) begin
      run(len, dn, dn2);
      if (i == 15 || i == 16) chk("R3 zero count run", dn, i == 16);
    end
    soft_start = 1'b1; @(negedge clk); soft_start = 1'b0;
    seen = 0;
    repeat (30) begin @(negedge clk); if (busy) seen = 1; end
    chk("R3 no service after terminal count", seen, 0);

    // R4 R5: priority order, late arrival latched
    do_reset();
    irq[5] = 1'b1; irq[2] = 1'b1; soft_start = 1'b1;
    @(negedge clk);
    irq = '0; soft_start = 1'b0;
    load(24'h001040, 24'h000080, 2'd0, 2'd0, 2'd0, CW'(8));
    for (int n = 0; n < 4; n++) begin
      wait_busy();
      ids[n] = int'(svc_id);
      if (n == 0) begin irq[0] = 1'b1; @(negedge clk); irq[0] = 1'b0; end
      len = 0;
      wait_idle(len);
    end
    chk("R5 first served", ids[0], 2);
    chk("R5 late request latched", ids[1], 0);
    chk("R5 third served", ids[2], 5);
    chk("R4 software start index", ids[3], 24);

    // R9: load during a transfer is ignored
    do_reset();
    src_wide = 1'b1; dst_wide = 1'b1;
    load(24'h001040, 24'h000080, 2'd0, 2'd1, 2'd1, CW'(5));
    clr_dmem();
    run(len, dn, dn2);
    soft_start = 1'b1; @(negedge clk); soft_start = 1'b0;
    wait_busy();
    cfg_src = 24'h001000; cfg_dst = 24'h0000C0; cfg_unit = 2'd2; cfg_count = CW'(1);
    cfg_load = 1'b1; @(negedge clk); cfg_load = 1'b0;
    len = 0;
    wait_idle(len);
    chk("R9 second transfer data", dmem[8'h81], pat(24'h001041));
    chk("R9 no done from ignored load", done, 0);
    run(len, dn, dn2);
    chk("R9 third transfer data", dmem[8'h82], pat(24'h001042));
    chk("R9 unit unchanged length", len, 8);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule